// File: doc/BRIEF.md
# Stopwatch Elapsed-Time Core

This block is the counting heart of a stopwatch. A single run flag decides whether time accumulates. Separate start and stop requests change the flag, and each request only acts when the flag is in the opposite state. A clear request zeroes the accumulated time and leaves the run flag as it was. While the flag is set, each cycle in which the time-base tick is high adds one fraction of a second to the elapsed time. The default is one hundredth, for a 100 Hz tick.

The elapsed time is held as a cascade of wrapping counters: fractions of a second, seconds, minutes and hours. Seconds, minutes, hours and the run flag are visible at the ports. Debouncing of user buttons and display encoding sit outside this block. An asynchronous reset stops the watch and zeroes the time.

Top module: `stopwatch_core`

## Requirements
- R1: While `rst_i` is high, and from the moment it rises, hours, minutes and seconds read 0 and `running_o` reads 0, with no clock edge needed.
- R2: When `start_i` is high, `stop_i` is low and the watch is stopped, `running_o` is 1 after the next clock edge. When the watch is already running, `start_i` has no effect.
- R3: When `stop_i` is high and the watch is running, `running_o` is 0 after the next clock edge. When the watch is stopped, `stop_i` has no effect. If `start_i` and `stop_i` are both high while stopped, the watch stays stopped.
- R4: When `clear_i` is high, hours, minutes and seconds all read 0 after the next edge. This holds even if a tick arrives in the same cycle. The run flag is not changed by `clear_i`.
- R5: The time advances by one fraction exactly on edges where `tick_i` is high, `clear_i` is low and the run flag resulting from that same cycle's start/stop decision is 1. A tick in the cycle of an accepted start counts. A tick in the cycle of an accepted stop does not count. Otherwise the time holds.
- R6: After `TICKS_PER_SEC` counted ticks (100 by default), the fraction field wraps to 0 and seconds increments by one.
- R7: Seconds (6 bits) run 0 to 59. On the wrap from 59 to 0, minutes increments.
- R8: Minutes (6 bits) run 0 to 59. On the wrap from 59 to 0, hours increments.
- R9: Hours (4 bits) run 0 to 15 and wrap from 15 to 0. The whole time then reads 0:00:00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| tick_i | input | 1 | Time-base tick, one fraction of a second per high cycle |
| start_i | input | 1 | Start request, sampled as a level each edge |
| stop_i | input | 1 | Stop request, sampled as a level each edge |
| clear_i | input | 1 | Zero the elapsed time |
| hours_o | output | 4 | Elapsed hours |
| minutes_o | output | 6 | Elapsed minutes |
| seconds_o | output | 6 | Elapsed seconds |
| running_o | output | 1 | Run flag |

## Verification
Every registered result appears one edge after the cycle that drives it. This covers the run flag after a start or stop, the zeroed time after a clear, and the advanced time after a tick. Only reset acts at once. The driver applies a cycle's inputs on the falling edge and queues the outputs expected after the following rising edge. The monitor samples one nanosecond after that rising edge, so each comparison falls in exactly the cycle where the registers have just changed. The asynchronous reset is checked between edges, to show it needs no clock.

// File: rtl/sw_pkg.sv
package sw_pkg;

    localparam int HOURS_W       = 4;
    localparam int MINS_W        = 6;
    localparam int SECS_W        = 6;
    localparam int SECS_PER_MIN  = 60;
    localparam int MINS_PER_HOUR = 60;
    localparam int HOURS_WRAP    = 1 << HOURS_W;
    localparam int DEFAULT_TICKS = 100;

    typedef struct packed {
        logic [HOURS_W-1:0] hours;
        logic [MINS_W-1:0]  minutes;
        logic [SECS_W-1:0]  seconds;
    } elapsed_t;

endpackage

// File: rtl/sw_wrap_counter.sv
module sw_wrap_counter #(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] value_o
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

    typedef struct packed {
        logic [WIDTH-1:0] value;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d.value = '0;
        end else if (inc_i) begin
            if (cnt_q.value == LAST) begin
                cnt_d.value = '0;
            end else begin
                cnt_d.value = cnt_q.value + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value_o = cnt_q.value;

endmodule

// File: rtl/sw_run_ctrl.sv
module sw_run_ctrl (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic stop_i,
    output logic run_d_o,
    output logic run_q_o
);
    typedef struct packed {
        logic running;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // Stop outranks start; each acts only against the opposite state.
    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.running) begin
            if (stop_i) begin
                ctl_d.running = 1'b0;
            end
        end else begin
            if (start_i && !stop_i) begin
                ctl_d.running = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign run_d_o = ctl_d.running;
    assign run_q_o = ctl_q.running;

endmodule

// File: rtl/sw_time_chain.sv
module sw_time_chain
    import sw_pkg::*;
#(
    parameter int TICKS_PER_SEC = DEFAULT_TICKS
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     clr_i,
    input  logic     adv_i,
    output elapsed_t time_o
);
    localparam int FRAC_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [FRAC_W-1:0] FRAC_LAST = FRAC_W'(TICKS_PER_SEC - 1);
    localparam logic [SECS_W-1:0] SEC_LAST  = SECS_W'(SECS_PER_MIN - 1);
    localparam logic [MINS_W-1:0] MIN_LAST  = MINS_W'(MINS_PER_HOUR - 1);

    logic [FRAC_W-1:0]  frac;
    logic [SECS_W-1:0]  secs;
    logic [MINS_W-1:0]  mins;
    logic [HOURS_W-1:0] hrs;
    logic               sec_inc, min_inc, hr_inc;

    assign sec_inc = adv_i   && (frac == FRAC_LAST);
    assign min_inc = sec_inc && (secs == SEC_LAST);
    assign hr_inc  = min_inc && (mins == MIN_LAST);

    sw_wrap_counter #(.WIDTH(FRAC_W), .MODULUS(TICKS_PER_SEC)) u_frac (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(clr_i), .inc_i(adv_i), .value_o(frac)
    );

    sw_wrap_counter #(.WIDTH(SECS_W), .MODULUS(SECS_PER_MIN)) u_secs (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(clr_i), .inc_i(sec_inc), .value_o(secs)
    );

    sw_wrap_counter #(.WIDTH(MINS_W), .MODULUS(MINS_PER_HOUR)) u_mins (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(clr_i), .inc_i(min_inc), .value_o(mins)
    );

    sw_wrap_counter #(.WIDTH(HOURS_W), .MODULUS(HOURS_WRAP)) u_hrs (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(clr_i), .inc_i(hr_inc), .value_o(hrs)
    );

    always_comb begin
        time_o.hours   = hrs;
        time_o.minutes = mins;
        time_o.seconds = secs;
    end

endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
    import sw_pkg::*;
#(
    parameter int TICKS_PER_SEC = DEFAULT_TICKS
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               tick_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               clear_i,
    output logic [HOURS_W-1:0] hours_o,
    output logic [MINS_W-1:0]  minutes_o,
    output logic [SECS_W-1:0]  seconds_o,
    output logic               running_o
);
    logic     run_d, run_q, advance;
    elapsed_t elapsed;

    sw_run_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .stop_i  (stop_i),
        .run_d_o (run_d),
        .run_q_o (run_q)
    );

    // Clear outranks counting; the run decision of this cycle gates the tick.
    assign advance = tick_i && run_d && !clear_i;

    sw_time_chain #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chain (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (clear_i),
        .adv_i  (advance),
        .time_o (elapsed)
    );

    assign hours_o   = elapsed.hours;
    assign minutes_o = elapsed.minutes;
    assign seconds_o = elapsed.seconds;
    assign running_o = run_q;

endmodule

// File: rtl/stopwatch_core_chk.sv
module stopwatch_core_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       tick_i,
    input logic       start_i,
    input logic       stop_i,
    input logic       clear_i,
    input logic [3:0] hours_o,
    input logic [5:0] minutes_o,
    input logic [5:0] seconds_o,
    input logic       running_o
);
    // R1
    reset_zero_chk: assert property (@(posedge clk_i)
        rst_i |-> (hours_o == 4'd0 && minutes_o == 6'd0 && seconds_o == 6'd0 && !running_o));

    // R2
    start_sets_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!running_o && start_i && !stop_i) |=> running_o);

    // R3
    stop_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (running_o && stop_i) |=> !running_o);

    // R4
    clear_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_i |=> (hours_o == 4'd0 && minutes_o == 6'd0 && seconds_o == 6'd0));

    // R4
    clear_keeps_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clear_i && !start_i && !stop_i) |=> $stable(running_o));

    // R5
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clear_i && !tick_i) |=> ($stable(seconds_o) && $stable(minutes_o) && $stable(hours_o)));

    // R6
    sec_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(seconds_o) && !$past(clear_i)) |-> (seconds_o == $past(seconds_o) + 6'd1 || seconds_o == 6'd0));

    // R7
    min_carry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(minutes_o) && !$past(clear_i)) |-> (seconds_o == 6'd0 && $past(seconds_o) == 6'd59));

    // R8
    hour_carry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(hours_o) && !$past(clear_i)) |-> (minutes_o == 6'd0 && $past(minutes_o) == 6'd59));

    // R9
    hour_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(hours_o) && !$past(clear_i)) |-> (hours_o == $past(hours_o) + 4'd1));

endmodule

bind stopwatch_core stopwatch_core_chk u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .start_i(start_i),
    .stop_i(stop_i), .clear_i(clear_i), .hours_o(hours_o),
    .minutes_o(minutes_o), .seconds_o(seconds_o), .running_o(running_o)
);

// File: tb/tb_stopwatch_core.sv
`timescale 1ns/1ps
module tb_stopwatch_core;

    localparam int TPS      = 100;
    localparam int FAST_TPS = 2;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, tick, start, stop, clear;
    logic [3:0] hours;
    logic [5:0] minutes, seconds;
    logic running;

    logic f_rst, f_tick, f_start, f_stop, f_clear;
    logic [3:0] f_hours;
    logic [5:0] f_minutes, f_seconds;
    logic f_running;

    stopwatch_core #(.TICKS_PER_SEC(TPS)) dut (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .start_i(start), .stop_i(stop),
        .clear_i(clear), .hours_o(hours), .minutes_o(minutes), .seconds_o(seconds),
        .running_o(running)
    );

    stopwatch_core #(.TICKS_PER_SEC(FAST_TPS)) dut_fast (
        .clk_i(clk), .rst_i(f_rst), .tick_i(f_tick), .start_i(f_start), .stop_i(f_stop),
        .clear_i(f_clear), .hours_o(f_hours), .minutes_o(f_minutes), .seconds_o(f_seconds),
        .running_o(f_running)
    );

    typedef struct {
        int    h;
        int    m;
        int    s;
        int    run;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   ref_run = 1'b0;
    longint ref_total = 0;

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic exp_t model_view(input longint total, input bit run, input int tps, input string req);
        exp_t e;
        e.s   = int'((total / tps) % 60);
        e.m   = int'((total / (tps * 60)) % 60);
        e.h   = int'((total / (tps * 3600)) % 16);
        e.run = run;
        e.req = req;
        return e;
    endfunction

    // Driver: applies one cycle of inputs and queues the expected outputs.
    task automatic drive(input bit st, input bit sp, input bit cl, input bit tk, input string req);
        bit nrun;
        @(negedge clk);
        start = st; stop = sp; clear = cl; tick = tk;
        nrun = ref_run;
        if (ref_run && sp) nrun = 1'b0;
        else if (!ref_run && st && !sp) nrun = 1'b1;
        ref_run = nrun;
        if (cl) ref_total = 0;
        else if (tk && nrun) ref_total = (ref_total + 1) % (longint'(TPS) * 3600 * 16);
        q.push_back(model_view(ref_total, ref_run, TPS, req));
    endtask

    // Monitor: compares just after the edge that produced each result.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.req, "hours", int'(hours), e.h);
            cmp(e.req, "minutes", int'(minutes), e.m);
            cmp(e.req, "seconds", int'(seconds), e.s);
            cmp(e.req, "running", int'(running), e.run);
        end
    end

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
        @(posedge clk); #2;
    endtask

    task automatic fast_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            f_tick = 1'b1;
        end
        @(negedge clk);
        f_tick = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic fast_check(input string req, input int h, input int m, input int s);
        cmp(req, "fast hours", int'(f_hours), h);
        cmp(req, "fast minutes", int'(f_minutes), m);
        cmp(req, "fast seconds", int'(f_seconds), s);
    endtask

    initial begin
        #(4 * WATCHDOG);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; start = 1'b0; stop = 1'b0; clear = 1'b0;
        f_rst = 1'b1; f_tick = 1'b0; f_start = 1'b0; f_stop = 1'b0; f_clear = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        cmp("R1", "hours", int'(hours), 0);
        cmp("R1", "minutes", int'(minutes), 0);
        cmp("R1", "seconds", int'(seconds), 0);
        cmp("R1", "running", int'(running), 0);
        @(negedge clk);
        rst = 1'b0;

        drive(0, 0, 0, 1, "R5 tick while stopped");
        drive(1, 0, 0, 0, "R2 start");
        for (int i = 0; i < 5; i++) begin
            drive(0, 0, 0, 1, "R5 tick");
            drive(0, 0, 0, 0, "R5 idle");
        end
        drive(1, 0, 0, 1, "R2 start while running");
        drive(0, 1, 0, 1, "R3 stop with tick");
        drive(0, 1, 0, 0, "R3 stop while stopped");
        drive(1, 1, 0, 0, "R3 start and stop while stopped");
        drive(1, 0, 0, 1, "R5 start with tick");
        drive(0, 0, 1, 1, "R4 clear with tick running");
        drive(0, 0, 0, 0, "R4 run kept");
        for (int i = 0; i < TPS - 1; i++) drive(0, 0, 0, 1, "R6 fraction");
        drive(0, 0, 0, 1, "R6 second carry");
        for (int i = 0; i < TPS * 59; i++) drive(0, 0, 0, 1, "R7 minute carry");
        drive(0, 0, 0, 0, "R7 idle");
        drive(0, 1, 0, 0, "R3 stop");
        drive(0, 0, 1, 0, "R4 clear while stopped");
        drive(1, 0, 0, 0, "R2 restart");
        for (int i = 0; i < 7; i++) drive(0, 0, 0, 1, "R5 tick");
        drain();

        // R1: asynchronous reset between edges
        @(negedge clk);
        #0.5;
        rst = 1'b1;
        #0.5;
        cmp("R1 async", "seconds", int'(seconds), 0);
        cmp("R1 async", "running", int'(running), 0);
        @(negedge clk);
        rst = 1'b0;
        ref_run = 1'b0;
        ref_total = 0;
        drive(0, 0, 0, 1, "R1 stopped after reset");
        drain();

        // Fast instance: minute and hour carries, hour wrap
        @(negedge clk);
        f_rst = 1'b0;
        f_start = 1'b1;
        @(negedge clk);
        f_start = 1'b0;
        fast_ticks(FAST_TPS * 60 * 59);
        fast_check("R7", 0, 59, 0);
        fast_ticks(FAST_TPS * 60 - 1);
        fast_check("R8 before carry", 0, 59, 59);
        fast_ticks(1);
        fast_check("R8 hour carry", 1, 0, 0);
        fast_ticks(FAST_TPS * 3600 * 14 + FAST_TPS * 3600 - 1);
        fast_check("R9 max", 15, 59, 59);
        fast_ticks(1);
        fast_check("R9 wrap", 0, 0, 0);
        cmp("R9", "fast running", int'(f_running), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule